// File: doc/BRIEF.md
# Cascadable Segment Line Loader

This block fills one display line of 240 segment bits from a narrow parallel bus, for a driver that may sit in a chain with other drivers. A line pulse clears the loader. The chip then stays idle until the enable from the chip before it goes low. From that point each falling edge of the shift clock brings in data: one byte per edge in byte mode, or one nibble per edge in nibble mode, where two nibbles make a byte. Each byte is steered into the wide latch by a one-hot group pointer. The pointer moves by one 16-bit group for every two bytes, and a direction input sets which way it walks.

After the thirtieth byte the loader drives its own cascade enable low, so the next chip in the chain becomes active. It then ignores the shift clock until the next line pulse. On the falling edge of the line pulse, the whole latch is copied at once into a line register that drives the segment outputs. The line register holds that value while the following line loads. All inputs are taken to be synchronous to `clk_i`. The shift clock and the line pulse are sampled levels, and their edges are found by comparing each sample with the one before.

Top module: `seg_line_loader`

## Requirements
- R1: While `rst_ni` is low, `en_no` is 1 and `line_o` is all zeros.
- R2: After a line pulse, shift-clock falling edges seen while `en_ni` is high write nothing, and the first byte taken after selection lands in the first latch position.
- R3: In byte mode (`mode8_i`=1) with `dir_i`=0, the byte taken on the k-th accepted falling edge of `xck_i` (k counted from 0) is stored in latch bits [8k+7:8k].
- R4: In nibble mode (`mode8_i`=0), `din_i[3:0]` on the first edge of a pair becomes bits [7:4] of the byte, `din_i[3:0]` on the second edge becomes bits [3:0], and `din_i[7:4]` is not used.
- R5: With `dir_i`=1 when the chip is selected, byte k is stored in latch bits [239-8k:232-8k].
- R6: `en_no` goes low by the second clock edge after the falling edge of `xck_i` that completes byte 30. Before that it is 1. It stays low until `lp_i` goes high.
- R7: Shift-clock edges after the line is complete change no latch bit.
- R8: `line_o` changes only on a clock edge where `lp_i` has just fallen from 1 to 0. At that edge it takes all 240 latch bits together.
- R9: While `lp_i` is high, the loader returns to idle. `en_no` goes to 1, and the pointer, byte count and nibble phase are cleared. Latch bits not written in a partial line keep their earlier values.
- R10: Shift-clock edges seen while `lp_i` is high write nothing.
- R11: Loading starts one cycle after `en_ni` is sampled low with `lp_i` low. This includes the case where `en_ni` is already low when `lp_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lp_i | input | 1 | Line pulse. High clears the loader; its fall transfers the latch |
| xck_i | input | 1 | Shift clock. Data is taken on its falling edge |
| en_ni | input | 1 | Cascade enable from the previous chip, active low |
| dir_i | input | 1 | Fill direction: 0 fills from the low bits up, 1 from the high bits down |
| mode8_i | input | 1 | 1 selects byte input, 0 selects nibble input on din_i[3:0] |
| din_i | input | 8 | Parallel data |
| en_no | output | 1 | Cascade enable to the next chip, active low |
| line_o | output | 240 | Line register contents |

## Verification
The line transfer and the chip selection for the next line can happen on the same clock edge when `en_ni` is held low across a line pulse. The bench holds the enable low through a pulse and then loads a full line at once. It checks that `line_o` shows the latch from before the pulse, and that the first new byte lands in the first position in the new direction. A second overlap is a shift-clock edge that arrives while the line pulse is high. The bench drives such edges, and the line transferred at the end of that pulse must match the latch as it was before them.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_DONE = 2'd2
  } ld_state_t;
endpackage

// File: rtl/seg_edge_det.sv
module seg_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign fall_o = sig_q & ~sig_i;
endmodule

// File: rtl/seg_word_pack.sv
module seg_word_pack #(
  parameter int BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             take_i,
  input  logic             mode8_i,
  input  logic [BUS_W-1:0] din_i,
  output logic [BUS_W-1:0] word_o,
  output logic             vld_o
);
  localparam int NIB = BUS_W / 2;

  logic           phase_q;
  logic [NIB-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      hi_q    <= '0;
      word_o  <= '0;
      vld_o   <= 1'b0;
    end else if (clr_i) begin
      phase_q <= 1'b0;
      vld_o   <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (take_i) begin
        if (mode8_i) begin
          word_o <= din_i;
          vld_o  <= 1'b1;
        end else if (!phase_q) begin
          hi_q    <= din_i[NIB-1:0];   // first nibble -> upper half
          phase_q <= 1'b1;
        end else begin
          word_o  <= {hi_q, din_i[NIB-1:0]};
          vld_o   <= 1'b1;
          phase_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/seg_load_ctrl.sv
module seg_load_ctrl
  import seg_loader_pkg::*;
#(
  parameter int GROUPS = 15,
  parameter int WPG    = 2,
  parameter int WORDS  = 30,
  localparam int SUB_W = (WPG > 1) ? $clog2(WPG) : 1,
  localparam int CNT_W = $clog2(WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lp_i,
  input  logic              en_ni,
  input  logic              dir_i,
  input  logic              wr_i,
  output ld_state_t         state_o,
  output logic [GROUPS-1:0] ptr_o,
  output logic [SUB_W-1:0]  sub_o,
  output logic              dir_o,
  output logic              en_no
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      ptr_o   <= '0;
      sub_o   <= '0;
      cnt_q   <= '0;
      dir_o   <= 1'b0;
      en_no   <= 1'b1;
    end else if (lp_i) begin
      state_o <= ST_IDLE;
      ptr_o   <= '0;
      sub_o   <= '0;
      cnt_q   <= '0;
      en_no   <= 1'b1;
    end else begin
      unique case (state_o)
        ST_IDLE: begin
          if (!en_ni) begin
            state_o <= ST_LOAD;
            dir_o   <= dir_i;
            ptr_o   <= dir_i ? {1'b1, {(GROUPS-1){1'b0}}} : GROUPS'(1);
            sub_o   <= '0;
            cnt_q   <= '0;
          end
        end
        ST_LOAD: begin
          if (wr_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (sub_o == SUB_W'(WPG - 1)) begin
              sub_o <= '0;
              ptr_o <= dir_o ? (ptr_o >> 1) : (ptr_o << 1);
            end else begin
              sub_o <= sub_o + 1'b1;
            end
            if (cnt_q == CNT_W'(WORDS - 1)) begin
              state_o <= ST_DONE;
              ptr_o   <= '0;
              en_no   <= 1'b0;
            end
          end
        end
        ST_DONE: ;
        default: state_o <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_latch_bank.sv
module seg_latch_bank #(
  parameter int BUS_W  = 8,
  parameter int GROUPS = 15,
  parameter int WPG    = 2,
  localparam int SUB_W = (WPG > 1) ? $clog2(WPG) : 1,
  localparam int CELLS = GROUPS * WPG,
  localparam int LINE  = CELLS * BUS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BUS_W-1:0]  word_i,
  input  logic [GROUPS-1:0] ptr_i,
  input  logic [SUB_W-1:0]  sub_i,
  input  logic              dir_i,
  input  logic              lp_fall_i,
  output logic [LINE-1:0]   line_o
);
  logic [LINE-1:0]  latch_q;
  logic [CELLS-1:0] we;
  logic [SUB_W-1:0] slot;

  // descending fill takes the upper byte of a group first
  assign slot = dir_i ? (SUB_W'(WPG - 1) - sub_i) : sub_i;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar b = 0; b < WPG; b++) begin : g_cell
      assign we[g*WPG + b] = wr_i & ptr_i[g] & (slot == SUB_W'(b));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
    end else begin
      for (int i = 0; i < CELLS; i++) begin
        if (we[i]) latch_q[i*BUS_W +: BUS_W] <= word_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        line_o <= '0;
    else if (lp_fall_i) line_o <= latch_q;
  end
endmodule

// File: rtl/seg_line_loader.sv
module seg_line_loader
  import seg_loader_pkg::*;
#(
  parameter int LINE_BITS  = 240,
  parameter int BUS_W      = 8,
  parameter int GROUP_BITS = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lp_i,
  input  logic                 xck_i,
  input  logic                 en_ni,
  input  logic                 dir_i,
  input  logic                 mode8_i,
  input  logic [BUS_W-1:0]     din_i,
  output logic                 en_no,
  output logic [LINE_BITS-1:0] line_o
);
  localparam int GROUPS = LINE_BITS / GROUP_BITS;
  localparam int WPG    = GROUP_BITS / BUS_W;
  localparam int WORDS  = LINE_BITS / BUS_W;
  localparam int SUB_W  = (WPG > 1) ? $clog2(WPG) : 1;

  logic              xck_fall;
  logic              lp_fall;
  logic [BUS_W-1:0]  word;
  logic              word_vld;
  ld_state_t         state_q;
  logic [GROUPS-1:0] grp_ptr;
  logic [SUB_W-1:0]  sub_idx;
  logic              dir_q;

  seg_edge_det u_xck_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (xck_i),
    .fall_o(xck_fall)
  );

  seg_edge_det u_lp_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (lp_i),
    .fall_o(lp_fall)
  );

  seg_word_pack #(.BUS_W(BUS_W)) u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (lp_i),
    .take_i (xck_fall && (state_q == ST_LOAD)),
    .mode8_i(mode8_i),
    .din_i  (din_i),
    .word_o (word),
    .vld_o  (word_vld)
  );

  seg_load_ctrl #(.GROUPS(GROUPS), .WPG(WPG), .WORDS(WORDS)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lp_i   (lp_i),
    .en_ni  (en_ni),
    .dir_i  (dir_i),
    .wr_i   (word_vld),
    .state_o(state_q),
    .ptr_o  (grp_ptr),
    .sub_o  (sub_idx),
    .dir_o  (dir_q),
    .en_no  (en_no)
  );

  seg_latch_bank #(.BUS_W(BUS_W), .GROUPS(GROUPS), .WPG(WPG)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (word_vld),
    .word_i   (word),
    .ptr_i    (grp_ptr),
    .sub_i    (sub_idx),
    .dir_i    (dir_q),
    .lp_fall_i(lp_fall),
    .line_o   (line_o)
  );
endmodule

// File: rtl/seg_line_loader_chk.sv
module seg_line_loader_chk
  import seg_loader_pkg::*;
#(
  parameter int LINE_BITS = 240,
  parameter int GROUPS    = 15
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 lp_i,
  input logic                 en_no,
  input logic [LINE_BITS-1:0] line_o,
  input ld_state_t            state_q,
  input logic                 word_vld,
  input logic [GROUPS-1:0]    grp_ptr
);
  logic lp_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lp_d <= 1'b0;
    else         lp_d <= lp_i;
  end

  a_r6_eo_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_no && !lp_i) |=> !en_no);

  a_r9_lp_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_i |=> (en_no && state_q == ST_IDLE));

  a_r7_write_only_loading: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld |-> state_q == ST_LOAD);

  a_r3_ptr_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grp_ptr));

  a_r8_line_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lp_d && !lp_i) |=> $stable(line_o));
endmodule

bind seg_line_loader seg_line_loader_chk #(
  .LINE_BITS(LINE_BITS),
  .GROUPS   (GROUPS)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .lp_i    (lp_i),
  .en_no   (en_no),
  .line_o  (line_o),
  .state_q (state_q),
  .word_vld(word_vld),
  .grp_ptr (grp_ptr)
);

// File: tb/seg_line_loader_tb.sv
module seg_line_loader_tb;
  localparam int LB = 240;
  localparam int NW = 30;
  // {mode8, dir, pre_edges[1:0], seed[7:0]}
  localparam logic [11:0] VEC [6] = '{
    {1'b1, 1'b0, 2'd0, 8'h00},
    {1'b1, 1'b0, 2'd3, 8'h3C},
    {1'b0, 1'b0, 2'd1, 8'h81},
    {1'b1, 1'b1, 2'd2, 8'h5A},
    {1'b0, 1'b1, 2'd0, 8'hF0},
    {1'b0, 1'b0, 2'd2, 8'h17}
  };

  logic          clk = 1'b0;
  logic          rst_ni, lp, xck, en_n, dir, mode8;
  logic [7:0]    din;
  logic          eo_n;
  logic [LB-1:0] line;

  int            checks = 0;
  int            fails  = 0;
  logic [LB-1:0] exp_latch = '0;
  logic [LB-1:0] exp_line  = '0;
  string         prev_tag  = "R1";

  always #2 clk = ~clk;

  seg_line_loader u_dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .lp_i   (lp),
    .xck_i  (xck),
    .en_ni  (en_n),
    .dir_i  (dir),
    .mode8_i(mode8),
    .din_i  (din),
    .en_no  (eo_n),
    .line_o (line)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_line(input string tag, input logic [LB-1:0] act, input logic [LB-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_raw(input logic [7:0] d);
    din = d;
    xck = 1'b1;
    wait_n(2);
    xck = 1'b0;
    wait_n(2);
  endtask

  task automatic send_word(input logic m8, input logic [7:0] w);
    if (m8) begin
      send_raw(w);
    end else begin
      send_raw({~w[7:4], w[7:4]});
      send_raw({4'hC ^ w[3:0], w[3:0]});
    end
  endtask

  task automatic put_model(input logic d, input int k, input logic [7:0] w);
    if (!d) exp_latch[8*k +: 8] = w;
    else    exp_latch[LB-1-8*k -: 8] = w;
  endtask

  task automatic lp_pulse();
    lp = 1'b1;
    wait_n(2);
    lp = 1'b0;
    exp_line = exp_latch;
    wait_n(2);
  endtask

  task automatic load_line(input logic m8, input logic d, input logic [7:0] seed, input string tag);
    for (int k = 0; k < NW; k++) begin
      logic [7:0] w;
      w = seed + 8'(k * 29);
      send_word(m8, w);
      put_model(d, k, w);
      if (k == 14) check_line({tag, " R8 line stable while loading"}, line, exp_line);
      if (k == NW - 2) check_bit("R6 eo high before last byte", eo_n, 1'b1);
    end
    check_bit("R6 eo low after last byte", eo_n, 1'b0);
  endtask

  initial begin
    #(100000 * 4);
    fails++;
    $display("FAIL watchdog R6 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; lp = 1'b0; xck = 1'b0; en_n = 1'b1;
    dir = 1'b0; mode8 = 1'b1; din = '0;
    wait_n(3);
    check_bit("R1 eo in reset", eo_n, 1'b1);
    check_line("R1 line in reset", line, '0);
    rst_ni = 1'b1;
    wait_n(2);

    // table walk
    for (int v = 0; v < 6; v++) begin
      logic       m8, dr;
      logic [1:0] pre;
      logic [7:0] seed;
      string      tag;
      {m8, dr, pre, seed} = VEC[v];
      tag   = m8 ? (dr ? "R5" : "R3") : "R4";
      mode8 = m8;
      dir   = dr;
      en_n  = 1'b1;
      lp_pulse();
      check_line({prev_tag, " line after transfer"}, line, exp_line);
      check_bit("R9 eo high after line pulse", eo_n, 1'b1);
      for (int p = 0; p < int'(pre); p++) send_raw(8'hA5);  // R2: unselected
      en_n = 1'b0;
      wait_n(2);
      load_line(m8, dr, seed, (pre != 0) ? {tag, " R2"} : tag);
      send_raw(8'h66);  // R7: after completion
      send_raw(8'h99);
      check_bit("R6 eo stays low", eo_n, 1'b0);
      prev_tag = (pre != 0) ? {tag, " R2 R7"} : {tag, " R7"};
    end
    en_n = 1'b1;
    lp_pulse();
    check_line({prev_tag, " final table line"}, line, exp_line);

    // R10: edges during a high line pulse
    mode8 = 1'b1; dir = 1'b0;
    lp = 1'b1;
    wait_n(1);
    send_raw(8'h12); send_raw(8'h34); send_raw(8'h56);
    lp = 1'b0;
    exp_line = exp_latch;
    wait_n(2);
    check_line("R10 edges in line pulse ignored", line, exp_line);

    // R9: partial line in nibble mode, odd nibble left pending
    mode8 = 1'b0;
    en_n = 1'b0;
    wait_n(2);
    for (int k = 0; k < 5; k++) begin
      send_word(1'b0, 8'h11 + 8'(k));
      put_model(1'b0, k, 8'h11 + 8'(k));
    end
    send_raw(8'h0E);
    check_bit("R9 eo high on partial line", eo_n, 1'b1);
    en_n = 1'b1;
    lp_pulse();
    check_line("R9 partial line over stale bits", line, exp_line);
    en_n = 1'b0;
    wait_n(2);
    load_line(1'b0, 1'b0, 8'h2B, "R9 R4");
    en_n = 1'b1;
    lp_pulse();
    check_line("R9 restart at first position and phase", line, exp_line);

    // R11: enable held low across the pulse, transfer and selection coincide
    mode8 = 1'b1; dir = 1'b1;
    en_n  = 1'b0;
    lp_pulse();
    check_line("R11 R8 transfer with enable low", line, exp_line);
    load_line(1'b1, 1'b1, 8'hC3, "R11 R5");
    en_n = 1'b1;
    lp_pulse();
    check_line("R11 R5 line after overlap", line, exp_line);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule